// File: doc/BRIEF.md
# Time-Compare Event and Input Capture Unit

This unit turns a free-running 64-bit time value into scheduled events. A programmable target is compared against the time on every cycle. When the time has reached or passed the target, the unit records a compare event and drives its event outputs. In the same cycle it moves the target on, either by loading a reload value or by adding that value as a period. The compare tests greater-than-or-equal, so it still fires when the time source is stepped past the target. The automatic update gives periodic pulse trains without host involvement.

Two general-purpose inputs are synchronised and edge-detected, each with its own polarity select. The active edge latches the current time into that input's capture register. The compare event and the two capture events each set a sticky flag, which the host clears by writing 1. The flags are masked by per-flag enables and ORed into one interrupt line.

There are three state machines. The compare machine has the states CMP_DISARMED and CMP_ARMED. It goes from CMP_DISARMED to CMP_ARMED on a target write and then stays in CMP_ARMED. Each capture channel has the states CAP_INIT, CAP_LOW and CAP_HIGH. CAP_INIT moves to CAP_LOW or CAP_HIGH on the first cycle after reset, taking the current level. CAP_LOW moves to CAP_HIGH on an active edge, and that transition is the capture. CAP_HIGH moves to CAP_LOW when the level returns. Each event output has the states OUT_IDLE and OUT_PULSE. OUT_IDLE moves to OUT_PULSE on a hit in pulse mode. OUT_PULSE stays in OUT_PULSE on a further pulse-mode hit, which restarts the count. OUT_PULSE returns to OUT_IDLE when the count expires or on a toggle-mode hit.

Top module: `tcmp_event_unit`

## Requirements
- R1: After reset the target, captures, flags, event outputs and interrupt are all zero and the compare is disarmed: no compare event occurs, whatever the time, until the first target write.
- R2: While armed, a compare hit occurs on a clock edge where the unsigned time is greater than or equal to the target, except on an edge that writes the target. A hit sets flag bit 0 at that edge.
- R3: With add_mode low, a hit replaces the target with reload_val at the hit edge.
- R4: With add_mode high, a hit replaces the target with target plus reload_val, modulo 2^64.
- R5: A target value produces only one hit. After the update, no new hit occurs until the time reaches the new target.
- R6: Each input passes through a two-flop synchroniser and is then inverted when its gpi_fall bit is 1, so 0 selects rising edges and 1 selects falling edges. When the resulting level goes from 0 to 1, the third rising clock edge after the pin changes stores time_in into that input's capture slice and sets flag bit 1+i. The opposite edge captures nothing.
- R7: An output with its out_pulse_mode bit at 0 is in toggle mode. On a hit its gpo bit inverts at the hit edge if out_en is set for it, and stays unchanged if out_en is clear.
- R8: An output with its out_pulse_mode bit at 1 is in pulse mode. On an enabled hit its gpo bit goes high at the hit edge and stays high for max(pulse_len,1) cycles, then returns low. A hit during the pulse restarts the count.
- R9: Writing 1 to a flag_clr bit clears that flag at the next edge. If the flag's event occurs on the same edge, the flag stays set.
- R10: irq is the OR of flags ANDed with irq_en. It follows the flags with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | 64 | Current value of the tunable time source |
| tgt_wr | input | 1 | Host target write strobe |
| tgt_wdata | input | 64 | Target value to write |
| add_mode | input | 1 | 0: reload on hit, 1: add reload_val on hit |
| reload_val | input | 64 | Reload value or period |
| out_en | input | 2 | Per-output enable for compare events |
| out_pulse_mode | input | 2 | Per-output mode, 0 toggle, 1 pulse |
| pulse_len | input | 16 | Pulse length in cycles (0 acts as 1) |
| gpi | input | 2 | Asynchronous capture inputs |
| gpi_fall | input | 2 | Per-input edge select, 1 = falling |
| irq_en | input | 3 | Per-flag interrupt enable |
| flag_clr | input | 3 | Write-1-to-clear strobes for the flags |
| target_q | output | 64 | Current compare target |
| gpo | output | 2 | Event outputs |
| cap_time | output | 128 | Capture registers, input i in bits [64i+63:64i] |
| flags | output | 3 | Sticky flags: bit 0 compare, bits 1..2 inputs 0..1 |
| irq | output | 1 | Combined interrupt |

## Verification
A compare result is due on the first rising edge after the time or target is driven. The flag, the updated target and the event outputs all change on that edge. Capture results are due on the third edge after a pin change, because two synchroniser flops and the edge-detect state come first. The bench checks one cycle earlier that nothing has been captured yet. Every input is driven and every output sampled on the falling edge, and each check counts the rising edges between the drive and the sample, including the extra edges needed to cover a whole pulse length.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    typedef enum logic {
        CMP_DISARMED,
        CMP_ARMED
    } cmp_state_t;

    typedef enum logic [1:0] {
        CAP_INIT,
        CAP_LOW,
        CAP_HIGH
    } cap_state_t;

    typedef enum logic {
        OUT_IDLE,
        OUT_PULSE
    } out_state_t;

    localparam int FLAG_CMP = 0;
    localparam int FLAG_CAP_BASE = 1;
endpackage

// File: rtl/tcmp_compare.sv
module tcmp_compare
    import tcmp_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_in,
    input  logic          tgt_wr,
    input  logic [TW-1:0] tgt_wdata,
    input  logic          add_mode,
    input  logic [TW-1:0] reload_val,
    output logic [TW-1:0] target_q,
    output logic          hit
);
    cmp_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_DISARMED: if (tgt_wr) state_d = CMP_ARMED;
            CMP_ARMED:    state_d = CMP_ARMED;
            default:      state_d = CMP_DISARMED;
        endcase
    end

    assign hit = (state_q == CMP_ARMED) && !tgt_wr && (time_in >= target_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (tgt_wr) begin
            target_q <= tgt_wdata;
        end else if (hit) begin
            target_q <= add_mode ? (target_q + reload_val) : reload_val;
        end
    end

    a_r3_reload_target: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !add_mode) |=> (target_q == $past(reload_val)));

    a_r4_add_target: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && add_mode) |=> (target_q == $past(target_q) + $past(reload_val)));

    a_r1_no_hit_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_DISARMED) |-> !hit);
endmodule

// File: rtl/tcmp_capture.sv
module tcmp_capture
    import tcmp_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic          fall_sel,
    input  logic [TW-1:0] time_in,
    output logic [TW-1:0] cap_q,
    output logic          cap_evt
);
    cap_state_t state_q, state_d;
    logic sync1_q, sync2_q;
    logic lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
        end
    end

    assign lvl = sync2_q ^ fall_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_INIT: state_d = lvl ? CAP_HIGH : CAP_LOW;
            CAP_LOW:  if (lvl)  state_d = CAP_HIGH;
            CAP_HIGH: if (!lvl) state_d = CAP_LOW;
            default:  state_d = CAP_INIT;
        endcase
    end

    assign cap_evt = (state_q == CAP_LOW) && lvl;

    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= time_in;
    end

    a_r6_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(time_in)));

    a_r6_no_capture_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_HIGH) |-> !cap_evt);
endmodule

// File: rtl/tcmp_outev.sv
module tcmp_outev
    import tcmp_pkg::*;
#(
    parameter int PLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit,
    input  logic           en,
    input  logic           pulse_mode,
    input  logic [PLW-1:0] pulse_len,
    output logic           pin
);
    out_state_t     state_q, state_d;
    logic [PLW-1:0] cnt_q;
    logic           trig;

    assign trig = hit && en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE:  if (trig && pulse_mode) state_d = OUT_PULSE;
            OUT_PULSE: begin
                if (trig)              state_d = pulse_mode ? OUT_PULSE : OUT_IDLE;
                else if (cnt_q == '0)  state_d = OUT_IDLE;
            end
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin   <= 1'b0;
            cnt_q <= '0;
        end else if (trig) begin
            if (pulse_mode) begin
                pin   <= 1'b1;
                cnt_q <= (pulse_len == '0) ? '0 : pulse_len - 1'b1;
            end else begin
                pin <= ~pin;
            end
        end else if (state_q == OUT_PULSE) begin
            if (cnt_q == '0) pin   <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !pulse_mode) |=> (pin != $past(pin)));

    a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && state_q == OUT_IDLE) |=> $stable(pin));

    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && pulse_mode) |=> pin);

    a_r8_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_PULSE && !trig && cnt_q == '0) |=> !pin);
endmodule

// File: rtl/tcmp_event_unit.sv
module tcmp_event_unit
    import tcmp_pkg::*;
#(
    parameter int TW   = 64,
    parameter int NGPI = 2,
    parameter int NGPO = 2,
    parameter int PLW  = 16,
    localparam int NF  = 1 + NGPI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TW-1:0]      time_in,
    input  logic               tgt_wr,
    input  logic [TW-1:0]      tgt_wdata,
    input  logic               add_mode,
    input  logic [TW-1:0]      reload_val,
    input  logic [NGPO-1:0]    out_en,
    input  logic [NGPO-1:0]    out_pulse_mode,
    input  logic [PLW-1:0]     pulse_len,
    input  logic [NGPI-1:0]    gpi,
    input  logic [NGPI-1:0]    gpi_fall,
    input  logic [NF-1:0]      irq_en,
    input  logic [NF-1:0]      flag_clr,
    output logic [TW-1:0]      target_q,
    output logic [NGPO-1:0]    gpo,
    output logic [NGPI*TW-1:0] cap_time,
    output logic [NF-1:0]      flags,
    output logic               irq
);
    logic          hit;
    logic [NF-1:0] set_vec;

    tcmp_compare #(.TW(TW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_in    (time_in),
        .tgt_wr     (tgt_wr),
        .tgt_wdata  (tgt_wdata),
        .add_mode   (add_mode),
        .reload_val (reload_val),
        .target_q   (target_q),
        .hit        (hit)
    );

    assign set_vec[FLAG_CMP] = hit;

    for (genvar i = 0; i < NGPI; i++) begin : g_cap
        tcmp_capture #(.TW(TW)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (gpi[i]),
            .fall_sel (gpi_fall[i]),
            .time_in  (time_in),
            .cap_q    (cap_time[i*TW +: TW]),
            .cap_evt  (set_vec[FLAG_CAP_BASE + i])
        );
    end

    for (genvar j = 0; j < NGPO; j++) begin : g_out
        tcmp_outev #(.PLW(PLW)) u_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit),
            .en         (out_en[j]),
            .pulse_mode (out_pulse_mode[j]),
            .pulse_len  (pulse_len),
            .pin        (gpo[j])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | set_vec;
    end

    assign irq = |(flags & irq_en);

    a_r2_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flags[FLAG_CMP]);

    for (genvar k = 0; k < NF; k++) begin : g_flag_chk
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> flags[k]);
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[k] && !set_vec[k]) |=> !flags[k]);
    end
endmodule

// File: tb/tcmp_event_unit_tb_top.sv
module tcmp_event_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [63:0]  time_in;
    logic         tgt_wr;
    logic [63:0]  tgt_wdata;
    logic         add_mode;
    logic [63:0]  reload_val;
    logic [1:0]   out_en;
    logic [1:0]   out_pulse_mode;
    logic [15:0]  pulse_len;
    logic [1:0]   gpi;
    logic [1:0]   gpi_fall;
    logic [2:0]   irq_en;
    logic [2:0]   flag_clr;
    logic [63:0]  target_q;
    logic [1:0]   gpo;
    logic [127:0] cap_time;
    logic [2:0]   flags;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tcmp_event_unit dut_i (
        .clk(clk), .rst_n(rst_n), .time_in(time_in), .tgt_wr(tgt_wr),
        .tgt_wdata(tgt_wdata), .add_mode(add_mode), .reload_val(reload_val),
        .out_en(out_en), .out_pulse_mode(out_pulse_mode), .pulse_len(pulse_len),
        .gpi(gpi), .gpi_fall(gpi_fall), .irq_en(irq_en), .flag_clr(flag_clr),
        .target_q(target_q), .gpo(gpo), .cap_time(cap_time), .flags(flags),
        .irq(irq)
    );

    localparam int NV = 6;
    localparam logic        V_ADD [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [63:0] V_TGT [NV] = '{64'd100, 64'd100, 64'd100,
        64'hFFFF_FFFF_FFFF_FFF0, 64'h1_0000_0000, 64'd5};
    localparam logic [63:0] V_RLD [NV] = '{64'd500, 64'd500, 64'd50,
        64'h20, 64'd9, 64'd7};
    localparam logic [63:0] V_TIME [NV] = '{64'd99, 64'd100, 64'd250,
        64'hFFFF_FFFF_FFFF_FFF5, 64'hFFFF_FFFF, 64'h8000_0000_0000_0000};
    localparam logic        V_HIT [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [63:0] V_EXP [NV] = '{64'd100, 64'd500, 64'd150,
        64'h10, 64'h1_0000_0000, 64'd12};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_target(input logic [63:0] v);
        time_in   = 64'd0;
        tgt_wr    = 1'b1;
        tgt_wdata = v;
        @(negedge clk);
        tgt_wr    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; time_in = '1; tgt_wr = 1'b0; tgt_wdata = '0;
        add_mode = 1'b0; reload_val = '0; out_en = '0; out_pulse_mode = '0;
        pulse_len = 16'd0; gpi = 2'b00; gpi_fall = 2'b10; irq_en = '0; flag_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state, disarmed despite maximal time
        chk("R1 flags", flags, 0);
        chk("R1 target", target_q, 0);
        chk("R1 gpo", gpo, 0);
        chk("R1 irq", irq, 0);
        chk("R1 captures", cap_time, 0);

        // R2 R3 R4: vector table
        for (int i = 0; i < NV; i++) begin
            write_target(V_TGT[i]);
            add_mode   = V_ADD[i];
            reload_val = V_RLD[i];
            time_in    = V_TIME[i];
            @(negedge clk);
            chk(V_ADD[i] ? "R2/R4 vec flag" : "R2/R3 vec flag", flags[0], V_HIT[i]);
            chk(V_ADD[i] ? "R4 vec target" : "R3 vec target", target_q, V_EXP[i]);
            time_in  = 64'd0;
            flag_clr = 3'b001;
            @(negedge clk);
            flag_clr = 3'b000;
        end

        // R5: one hit per target
        add_mode = 1'b1; reload_val = 64'd10;
        write_target(64'd10);
        time_in = 64'd10;
        @(negedge clk);
        chk("R5 first hit target", target_q, 64'd20);
        time_in = 64'd15; flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R5 no refire flag", flags[0], 1'b0);
        chk("R5 no refire target", target_q, 64'd20);
        time_in = 64'd20;
        @(negedge clk);
        chk("R5 next hit", {flags[0], target_q}, {1'b1, 64'd30});
        time_in = 64'd0; flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;

        // R7 R8: toggle on output 0, pulse of 3 on output 1
        add_mode = 1'b0; reload_val = '1;
        out_en = 2'b11; out_pulse_mode = 2'b10; pulse_len = 16'd3;
        write_target(64'd10);
        time_in = 64'd10;
        @(negedge clk);
        chk("R7/R8 hit edge gpo", gpo, 2'b11);
        @(negedge clk);
        chk("R8 pulse cycle 2", gpo, 2'b11);
        @(negedge clk);
        chk("R8 pulse cycle 3", gpo, 2'b11);
        @(negedge clk);
        chk("R8 pulse end", gpo, 2'b01);
        out_en = 2'b01;
        write_target(64'd20);
        time_in = 64'd20;
        @(negedge clk);
        chk("R7 toggle back, disabled output held", gpo, 2'b00);
        @(negedge clk);
        chk("R7 disabled output still low", gpo, 2'b00);
        out_en = 2'b00; time_in = 64'd0;
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;

        // R6: rising capture on input 0, exact timing
        time_in = 64'h1234;
        gpi[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 not before third edge", flags[1], 1'b0);
        time_in = 64'h5678;
        @(negedge clk);
        chk("R6 flag input0", flags[1], 1'b1);
        chk("R6 capture input0", cap_time[63:0], 64'h5678);
        time_in = 64'h9999; flag_clr = 3'b010;
        gpi[0] = 1'b0;
        @(negedge clk);
        flag_clr = 3'b000;
        repeat (4) @(negedge clk);
        chk("R6 falling ignored input0", {flags[1], cap_time[63:0]}, {1'b0, 64'h5678});

        // R6: input 1 selects falling edges
        time_in = 64'hAAAA;
        gpi[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 rising ignored input1", {flags[2], cap_time[127:64]}, {1'b0, 64'd0});
        gpi[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 falling capture input1", {flags[2], cap_time[127:64]}, {1'b1, 64'hAAAA});
        flag_clr = 3'b100;
        @(negedge clk);
        flag_clr = 3'b000;

        // R9: clear, then set wins over clear
        write_target(64'd100);
        time_in = 64'd200;
        @(negedge clk);
        chk("R9 flag set by hit", flags, 3'b001);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R9 write-1 clears", flags, 3'b000);
        write_target(64'd50);
        time_in = 64'd200; flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000; time_in = 64'd0;
        chk("R9 set wins over clear", flags, 3'b001);

        // R10: interrupt masking
        irq_en = 3'b110;
        #1;
        chk("R10 masked irq", irq, 1'b0);
        irq_en = 3'b001;
        #1;
        chk("R10 enabled irq", irq, 1'b1);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R10 irq drops with flag", irq, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule